// File: doc/BRIEF.md
# Four-Way Recency Stack with Selectable Fill Position

This block holds the replacement state of a four-way set-associative cache. For every set it keeps a complete recency ranking of the four lines. Slot 0 holds the most recently used line and the last slot holds the least recently used line. The tag lookup and the miss handler sit outside the block. They tell it which set is being accessed and whether the access was a hit to a known line or a fill after a miss. The block answers with the line to evict and with the current ranking of that set.

On a fill, a static configuration input selects where the new line enters the ranking:

- **Top entry:** the newcomer goes straight to the most recent slot.
- **Bottom entry:** the newcomer stays in the least recent slot. It climbs only when a later hit reuses it. This protects the working set from lines that are streamed through once and never reused.

All updates are registered and take effect at the next clock edge. The read path is combinational from the stored state of the addressed set.

Top module: `recency_stack`

## Requirements
- R1: After a synchronous active-low reset, every set holds the ranking line 0, 1, 2, 3, from most to least recent.
- R2: `order_out` packs the ranking of the addressed set with slot k at bits [2k+1:2k]. Slot 0 is the most recent and slot 3 the least recent. Each stored ranking is always a permutation of the four line numbers.
- R3: `victim_line` equals the line in slot 3 of the set selected by `acc_set`, combinationally.
- R4: A hit (`acc_op` = 1) to line L places L in slot 0. Every line that was ranked above L moves down one slot. Lines ranked below L keep their slots.
- R5: A hit to the line already in slot 0 leaves the ranking unchanged.
- R6: A fill (`acc_op` = 2) with `ins_at_lru` = 0 replaces the victim. The victim's line number moves to slot 0 and the other three lines each move down one slot.
- R7: A fill with `ins_at_lru` = 1 leaves the ranking unchanged. The filled line, still in slot 3, is promoted to slot 0 only by a later hit.
- R8: Updates become visible one cycle after the access. In the access cycle itself, the outputs show the ranking from before the update.
- R9: `acc_op` = 0 (idle) and `acc_op` = 3 (reserved) change no state.
- R10: An access to one set never alters the ranking of any other set.
- R11: Changing `ins_at_lru` does not reorder any stored ranking. It only affects later fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_op | input | 2 | Access kind: 0 idle, 1 hit, 2 fill, 3 reserved |
| acc_set | input | 2 | Set index of the access, and the set that is read out |
| hit_line | input | 2 | Line number of a hit |
| ins_at_lru | input | 1 | Fill position: 0 = most recent slot, 1 = least recent slot |
| victim_line | output | 2 | Line to replace in the addressed set |
| order_out | output | 8 | Ranking of the addressed set, slot 0 in the low bits |

## Verification
The bench targets four corner cases:

- **Deepest shift.** A hit to the line in the last slot shifts all three other lines. A design that got this wrong would drop or duplicate a line.
- **Slot 0 hit.** A hit to the line already in slot 0 must change nothing. A design that got this wrong would disturb the ranking.
- **Bottom-entry fill.** Such a fill must leave the ranking untouched. A design that got this wrong would quietly behave like top-entry insertion and fail the worked insert-then-reuse sequences.
- **Set and op isolation.** Accesses to one set, and reserved op codes, must leave everything else alone. A design that got this wrong would corrupt a neighbouring set's ranking, and that would show up in the full sweep of all sets.

Read timing is also checked on every access, so a design that made updates visible in the same cycle would fail there.

// File: rtl/rs_pkg.sv
// Shared types for the recency stack.
// Assumes: the access encoding below is decoded by the cache controller.
package rs_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_HIT  = 2'd1,
        OP_FILL = 2'd2,
        OP_RSVD = 2'd3
    } rs_op_e;
endpackage

// File: rtl/rs_locate.sv
// Finds the slot that holds a given line number within one ranking.
// Assumes: the ranking is a permutation, so exactly one slot matches.
module rs_locate #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] order,
    input  logic [WAY_W-1:0]           line,
    output logic [WAY_W-1:0]           pos
);
    // Scan every slot and record the one that holds the line.
    always_comb begin
        pos = '0;
        for (int k = 0; k < WAYS; k++) begin
            if (order[k] == line) pos = WAY_W'(k);
        end
    end
endmodule

// File: rtl/rs_update.sv
// Computes the next ranking of one set: promotes a line to slot 0 and
// shifts the lines above its old slot down by one.
// Assumes: pos is the current slot of tgt_line within cur_order.
module rs_update #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] cur_order,
    input  logic [WAY_W-1:0]           tgt_line,
    input  logic [WAY_W-1:0]           pos,
    input  logic                       promote,
    output logic [WAYS-1:0][WAY_W-1:0] nxt_order,
    output logic                       wr_en
);
    // Build the promoted ranking slot by slot.
    always_comb begin
        nxt_order[0] = tgt_line;
        for (int i = 1; i < WAYS; i++) begin
            nxt_order[i] = (WAY_W'(i) <= pos) ? cur_order[i-1] : cur_order[i];
        end
    end

    // Write only when a promotion is requested.
    assign wr_en = promote;
endmodule

// File: rtl/rs_store.sv
// Per-set ranking registers with one combinational read port and one
// write port.
// Assumes: NUM_SETS is a power of two, so every set index is valid.
module rs_store #(
    parameter int NUM_SETS = 4,
    parameter int WAYS     = 4,
    parameter int WAY_W    = $clog2(WAYS),
    parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SET_W-1:0]           rd_set,
    output logic [WAYS-1:0][WAY_W-1:0] rd_order,
    input  logic                       wr_en,
    input  logic [SET_W-1:0]           wr_set,
    input  logic [WAYS-1:0][WAY_W-1:0] wr_order
);
    logic [WAYS-1:0][WAY_W-1:0] set_q [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic [WAYS-1:0] seen;

        // Hold one set's ranking; reset to line k in slot k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < WAYS; k++) set_q[s][k] <= WAY_W'(k);
            end else if (wr_en && (wr_set == SET_W'(s))) begin
                set_q[s] <= wr_order;
            end
        end

        // Mark which line numbers appear in this set's ranking.
        always_comb begin
            seen = '0;
            for (int k = 0; k < WAYS; k++) seen[set_q[s][k]] = 1'b1;
        end

        // R2
        perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(seen) == WAYS);
    end

    // Read the addressed set.
    assign rd_order = set_q[rd_set];
endmodule

// File: rtl/recency_stack.sv
// Replacement state for a set-associative cache. Keeps a full recency
// ranking per set, reports the victim, and updates on hits and fills.
// A fill either goes to slot 0 or stays in the last slot (ins_at_lru).
// Assumes: hit_line is a line of the set; ins_at_lru is quasi-static.
module recency_stack
    import rs_pkg::*;
#(
    parameter int NUM_SETS = 4,
    parameter int WAYS     = 4,
    parameter int WAY_W    = $clog2(WAYS),
    parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 acc_op,
    input  logic [SET_W-1:0]           acc_set,
    input  logic [WAY_W-1:0]           hit_line,
    input  logic                       ins_at_lru,
    output logic [WAY_W-1:0]           victim_line,
    output logic [WAYS-1:0][WAY_W-1:0] order_out
);
    logic [WAYS-1:0][WAY_W-1:0] cur_order;
    logic [WAYS-1:0][WAY_W-1:0] nxt_order;
    logic [WAY_W-1:0]           tgt_line;
    logic [WAY_W-1:0]           tgt_pos;
    logic                       promote;
    logic                       wr_en;

    // Choose the line to move up: the hit line, or the victim on a fill.
    always_comb begin
        tgt_line = (acc_op == OP_HIT) ? hit_line : cur_order[WAYS-1];
        promote  = (acc_op == OP_HIT) || ((acc_op == OP_FILL) && !ins_at_lru);
    end

    rs_store #(.NUM_SETS(NUM_SETS), .WAYS(WAYS), .WAY_W(WAY_W), .SET_W(SET_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (acc_set),
        .rd_order (cur_order),
        .wr_en    (wr_en),
        .wr_set   (acc_set),
        .wr_order (nxt_order)
    );

    rs_locate #(.WAYS(WAYS), .WAY_W(WAY_W)) u_locate (
        .order (cur_order),
        .line  (tgt_line),
        .pos   (tgt_pos)
    );

    rs_update #(.WAYS(WAYS), .WAY_W(WAY_W)) u_update (
        .cur_order (cur_order),
        .tgt_line  (tgt_line),
        .pos       (tgt_pos),
        .promote   (promote),
        .nxt_order (nxt_order),
        .wr_en     (wr_en)
    );

    // Drive the outputs straight from the addressed set's state.
    assign order_out   = cur_order;
    assign victim_line = cur_order[WAYS-1];

    // R4
    hit_to_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_op) == OP_HIT && acc_set == $past(acc_set))
        |-> order_out[0] == $past(hit_line));

    // R6
    fill_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_op) == OP_FILL && !$past(ins_at_lru)
         && acc_set == $past(acc_set))
        |-> order_out[0] == $past(victim_line));

    // R7
    fill_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_op) == OP_FILL && $past(ins_at_lru)
         && acc_set == $past(acc_set))
        |-> order_out == $past(order_out));

    // R9
    no_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(acc_op) == OP_IDLE || $past(acc_op) == OP_RSVD)
         && acc_set == $past(acc_set))
        |-> $stable(order_out));
endmodule

// File: tb/recency_stack_tb.sv
`timescale 1ns/1ps
module recency_stack_tb;
    localparam int NUM_SETS = 4;
    localparam int WAYS     = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] acc_op = 2'd0;
    logic [1:0] acc_set = 2'd0;
    logic [1:0] hit_line = 2'd0;
    logic       ins_at_lru = 1'b0;
    logic [1:0] victim_line;
    logic [3:0][1:0] order_out;

    int model [NUM_SETS][WAYS];
    int checks = 0;
    int fails  = 0;
    logic [31:0] lfsr = 32'hACE1_2461;

    always #2.5 clk = ~clk;

    recency_stack #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_op(acc_op), .acc_set(acc_set),
        .hit_line(hit_line), .ins_at_lru(ins_at_lru),
        .victim_line(victim_line), .order_out(order_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Move a line to slot 0 of the model, shifting the lines above it down.
    task automatic promote(input int s, input int line);
        int p = 0;
        for (int k = 0; k < WAYS; k++) if (model[s][k] == line) p = k;
        for (int i = p; i > 0; i--) model[s][i] = model[s][i-1];
        model[s][0] = line;
    endtask

    // One access: drive at negedge, check pre-update outputs (R8), update model.
    task automatic access(input int op, input int s, input int line, input bit lru);
        @(negedge clk);
        acc_op = 2'(op); acc_set = 2'(s); hit_line = 2'(line); ins_at_lru = lru;
        #1;
        check("R3 victim", int'(victim_line), model[s][3]);
        for (int k = 0; k < WAYS; k++)
            check("R8/R4/R6/R7/R10 order slot", int'(order_out[k]), model[s][k]);
        @(posedge clk);
        if (op == 1) promote(s, line);
        else if (op == 2 && !lru) promote(s, model[s][3]);
    endtask

    task automatic expect_order(input string req, input int s, input int a,
                                input int b, input int c, input int d);
        @(negedge clk);
        acc_op = 2'd0; acc_set = 2'(s);
        #1;
        check(req, int'(order_out[0]), a);
        check(req, int'(order_out[1]), b);
        check(req, int'(order_out[2]), c);
        check(req, int'(order_out[3]), d);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < NUM_SETS; s++)
            for (int k = 0; k < WAYS; k++) model[s][k] = k;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: every set starts as 0,1,2,3
        for (int s = 0; s < NUM_SETS; s++) expect_order("R1 reset order", s, 0, 1, 2, 3);

        // R6 then R4: fill at top, hit 1, hit 0 on set 2
        access(2, 2, 0, 1'b0);
        expect_order("R6 fill top", 2, 3, 0, 1, 2);
        access(1, 2, 1, 1'b0);
        access(1, 2, 0, 1'b0);
        expect_order("R4 hits", 2, 0, 1, 3, 2);
        // R5: hit to slot 0 changes nothing
        access(1, 2, 0, 1'b0);
        expect_order("R5 top hit", 2, 0, 1, 3, 2);

        // R7: two bottom fills, hit 3, hit 1 on set 1
        access(2, 1, 0, 1'b1);
        access(2, 1, 0, 1'b1);
        expect_order("R7 bottom fills", 1, 0, 1, 2, 3);
        access(1, 1, 3, 1'b1);
        access(1, 1, 1, 1'b1);
        expect_order("R7 reuse promote", 1, 1, 3, 0, 2);

        // R9: reserved op changes nothing
        access(3, 1, 2, 1'b0);
        expect_order("R9 reserved op", 1, 1, 3, 0, 2);
        // R10: sets 0 and 3 untouched
        expect_order("R10 set 0 isolated", 0, 0, 1, 2, 3);
        expect_order("R10 set 3 isolated", 3, 0, 1, 2, 3);

        // R11: toggling policy alone does not reorder
        @(negedge clk) ins_at_lru = 1'b1;
        expect_order("R11 policy toggle", 2, 0, 1, 3, 2);

        // Mixed sweep over all sets, ops, lines and both policies
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            access(int'(lfsr[1:0]), int'(lfsr[5:4]), int'(lfsr[9:8]), lfsr[12]);
        end
        for (int s = 0; s < NUM_SETS; s++) access(0, s, 0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule